// File: doc/BRIEF.md
# Single-Clock FIFO with Coarse Level Codes

This block is a first-in first-out buffer whose producer and consumer share one clock. A producer offers a word with `put`. The word is taken on the next rising edge unless `full` is high. A consumer sees the oldest stored word on `dout` whenever `valid` is high, and removes it by raising `got` for one edge. The requested minimum depth is rounded up to a power of two, never below two. Storage is a plain register array.

Two coarse status codes come next to the handshakes. `fill_code` is a floor-quantized fraction of the capacity that is certainly occupied. `free_code` is a floor-quantized fraction that can certainly still be written. Each code is a lower bound, so flow control must still use `full` and `valid`. Setting a code's width parameter to zero removes that code. Its port then stays one bit wide and is tied to 0.

Control is a three-state machine. The states are EMPTY, PARTIAL and FULL. The transitions are:
- fill-start (EMPTY to PARTIAL, on an accepted put)
- top-off (PARTIAL to FULL, on a put without a removal when one slot is left)
- drain-out (PARTIAL to EMPTY, on a removal without a put when one word is left)
- release (FULL to PARTIAL, on a removal)

Every other case keeps the current state.

Top module: `sync_fifo_quant`

## Requirements
- R1: While `rst` is high at a clock edge, the FIFO empties. Afterwards `valid`=0, `full`=0, `fill_code`=0, and `free_code` is all ones.
- R2: A word on `din` is stored on a rising edge where `put`=1 and `full`=0. `full` goes high exactly when the stored count equals the depth.
- R3: A `put` while `full`=1 is ignored. The stored contents and the order of later reads are unchanged.
- R4: `valid` is high exactly when at least one word is stored. While it is high, `dout` shows the oldest word. A `got` with `valid`=1 removes that word on the edge.
- R5: Words leave in exactly the order in which they were accepted.
- R6: If `put` and `got` are both high while the FIFO is neither empty nor full, the count is unchanged and both handshakes take effect.
- R7: A `got` while `valid`=0 is ignored. A `put` in the same cycle is still stored, and `valid` rises after that edge.
- R8: With the stored count c and depth D, `fill_code` equals min(floor(c·2^FILL_W/D), 2^FILL_W−1).
- R9: `free_code` equals min(floor((D−c)·2^FREE_W/D), 2^FREE_W−1).
- R10: The depth is the smallest power of two that is at least MIN_DEPTH and at least 2. With MIN_DEPTH=10, exactly 16 words are accepted before `full`.
- R11: With a code width parameter of 0, that code's port is constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| put | input | 1 | Write request |
| din | input | WORD_W | Word to write |
| full | output | 1 | No free slot; a put is ignored |
| got | input | 1 | Remove the head word |
| valid | output | 1 | A word is present on dout |
| dout | output | WORD_W | Oldest stored word |
| fill_code | output | max(FILL_W,1) | Lower bound on the occupied fraction |
| free_code | output | max(FREE_W,1) | Lower bound on the free fraction |

## Verification
The hardest condition to reach from the ports is a full FIFO whose contents must be shown untouched after puts were refused. The stimulus keeps `put` high for several cycles past the point where `full` rises. It then drains the FIFO while a scoreboard compares every word with the accepted order. The other two corners are a combined put and removal when the FIFO holds exactly one word, and a combined put and removal when it is one short of full. A long random phase with a bias toward writing drives the count through every code boundary. A second phase with a bias toward reading does the same on the way down.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

    // Control states of the occupancy machine.
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } sfq_state_e;

    // Smallest power of two that covers the request, never below two.
    function automatic int depth_round(input int min_words);
        int d;
        d = 2;
        while (d < min_words) d = d * 2;
        return d;
    endfunction

endpackage

// File: rtl/sfq_store.sv
module sfq_store #(
    parameter int WORD_W = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int SLOTS = 1 << AW;

    logic [WORD_W-1:0] cells [SLOTS];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    // The head word is visible without a read cycle.
    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/sfq_ptr_ctrl.sv
module sfq_ptr_ctrl
    import sfq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          put,
    input  logic          got,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   occupancy,
    output logic          valid,
    output logic          full
);
    localparam int OCC_W = AW + 1;
    localparam int DEPTH = 1 << AW;

    sfq_state_e state, state_nxt;
    logic [AW:0] wr_ptr, rd_ptr;
    logic        take_put, take_got;

    assign take_put  = put & ~full;
    assign take_got  = got & valid;
    assign wr_en     = take_put;
    assign wr_addr   = wr_ptr[AW-1:0];
    assign rd_addr   = rd_ptr[AW-1:0];
    // The extra wrap bit turns the pointer difference into the count.
    assign occupancy = wr_ptr - rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (take_put) wr_ptr <= wr_ptr + 1'b1;
            if (take_got) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nxt;
    end

    // Transitions: fill-start, top-off, drain-out, release.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (take_put) state_nxt = ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (take_put && !take_got && occupancy == OCC_W'(DEPTH - 1))
                    state_nxt = ST_FULL;
                else if (take_got && !take_put && occupancy == OCC_W'(1))
                    state_nxt = ST_EMPTY;
            end
            ST_FULL: begin
                if (take_got) state_nxt = ST_PARTIAL;
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // Flow-control outputs decoded from the state.
    always_comb begin
        valid = 1'b0;
        full  = 1'b0;
        unique case (state)
            ST_EMPTY:   begin valid = 1'b0; full = 1'b0; end
            ST_PARTIAL: begin valid = 1'b1; full = 1'b0; end
            ST_FULL:    begin valid = 1'b1; full = 1'b1; end
            default:    begin valid = 1'b0; full = 1'b0; end
        endcase
    end

    // R3: a refused put leaves the write pointer alone
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && put) |=> (wr_ptr == $past(wr_ptr)));
    // R4: state-derived valid agrees with the pointer count
    a_r4_valid_tracks: assert property (@(posedge clk) disable iff (rst)
        valid == (occupancy != '0));
    // R2: full agrees with the pointer count
    a_r2_full_tracks: assert property (@(posedge clk) disable iff (rst)
        full == (occupancy == OCC_W'(DEPTH)));
    // R6: a balanced put and removal keeps the count
    a_r6_balanced: assert property (@(posedge clk) disable iff (rst)
        (put && got && valid && !full) |=> $stable(occupancy));
    // R7: a put into an empty FIFO raises valid, even with got high
    a_r7_empty_put: assert property (@(posedge clk) disable iff (rst)
        (!valid && put) |=> valid);
endmodule

// File: rtl/sfq_level.sv
module sfq_level #(
    parameter int AW = 4,
    parameter int N  = 2
) (
    input  logic [AW:0]  amount,
    output logic [N-1:0] code
);
    localparam int DEPTH = 1 << AW;
    localparam int SHIFT = AW - N;

    // Floor of amount * 2^N / DEPTH, saturated so that a full amount fits.
    always_comb begin
        if (amount >= (AW+1)'(DEPTH)) code = '1;
        else                          code = N'(amount >> SHIFT);
    end
endmodule

// File: rtl/sync_fifo_quant.sv
module sync_fifo_quant
    import sfq_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int MIN_DEPTH = 10,
    parameter int FILL_W    = 2,
    parameter int FREE_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            put,
    input  logic [WORD_W-1:0]               din,
    output logic                            full,
    input  logic                            got,
    output logic                            valid,
    output logic [WORD_W-1:0]               dout,
    output logic [(FILL_W>0?FILL_W:1)-1:0]  fill_code,
    output logic [(FREE_W>0?FREE_W:1)-1:0]  free_code
);
    localparam int DEPTH = depth_round(MIN_DEPTH);
    localparam int AW    = $clog2(DEPTH);
    localparam int OCC_W = AW + 1;

    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [AW:0]   occupancy, vacancy;

    sfq_ptr_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .put(put), .got(got),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .occupancy(occupancy), .valid(valid), .full(full)
    );

    sfq_store #(.WORD_W(WORD_W), .AW(AW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(din),
        .rd_addr(rd_addr), .rd_data(dout)
    );

    assign vacancy = OCC_W'(DEPTH) - occupancy;

    generate
        if (FILL_W > 0) begin : g_fill
            sfq_level #(.AW(AW), .N(FILL_W)) u_fill (.amount(occupancy), .code(fill_code));
            // R8: the fill code never claims more than is stored
            a_r8_fill_bound: assert property (@(posedge clk) disable iff (rst)
                (int'(fill_code) * DEPTH) <= (int'(occupancy) * (1 << FILL_W)));
        end else begin : g_nofill
            assign fill_code = '0;
        end

        if (FREE_W > 0) begin : g_free
            sfq_level #(.AW(AW), .N(FREE_W)) u_free (.amount(vacancy), .code(free_code));
            // R9: the free code never claims more room than exists
            a_r9_free_bound: assert property (@(posedge clk) disable iff (rst)
                (int'(free_code) * DEPTH) <= (int'(vacancy) * (1 << FREE_W)));
        end else begin : g_nofree
            assign free_code = '0;
        end
    endgenerate

    // R1: the cycle after reset shows an empty FIFO
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (!valid && !full));
endmodule

// File: tb/test_sync_fifo_quant.sv
`timescale 1ns/1ps
module test_sync_fifo_quant;
    localparam int EXP_DEPTH = 16;   // R10: MIN_DEPTH 10 rounds up to 16

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       put = 1'b0;
    logic       got = 1'b0;
    logic [7:0] din = '0;
    logic       full, valid, full_b, valid_b;
    logic [7:0] dout, dout_b;
    logic [1:0] fill_code, free_code;
    logic [0:0] fill_b, free_b;

    int checks = 0;
    int errors = 0;
    int cnt = 0;
    bit done = 0;
    logic [7:0] q[$];

    always #2.5 clk = ~clk;

    sync_fifo_quant #(.WORD_W(8), .MIN_DEPTH(10), .FILL_W(2), .FREE_W(2)) i_sync_fifo_quant (
        .clk(clk), .rst(rst), .put(put), .din(din), .full(full), .got(got),
        .valid(valid), .dout(dout), .fill_code(fill_code), .free_code(free_code));

    sync_fifo_quant #(.WORD_W(8), .MIN_DEPTH(10), .FILL_W(0), .FREE_W(1)) i_sync_fifo_quant_b (
        .clk(clk), .rst(rst), .put(put), .din(din), .full(full_b), .got(got),
        .valid(valid_b), .dout(dout_b), .fill_code(fill_b), .free_code(free_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int quant(input int amount, input int n);
        int e;
        e = (amount << n) / EXP_DEPTH;
        if (e > (1 << n) - 1) e = (1 << n) - 1;
        return e;
    endfunction

    // Driver: sets inputs just after an edge and records accepted words.
    task automatic step(input bit p, input bit g);
        @(posedge clk);
        #1;
        put = p;
        got = g;
        din = 8'($urandom);
        if (p && cnt < EXP_DEPTH) q.push_back(din);
    endtask

    // Monitor: compares outputs mid-cycle and applies the pending edge to the model.
    always @(negedge clk) begin
        if (rst) begin
            cnt = 0;
            q.delete();
        end else if (!done) begin
            bit pa, ga;
            chk(valid == (cnt > 0), "R4 valid", int'(valid), int'(cnt > 0));
            chk(full == (cnt == EXP_DEPTH), "R2/R10 full", int'(full), int'(cnt == EXP_DEPTH));
            chk(int'(fill_code) == quant(cnt, 2), "R8 fill_code", int'(fill_code), quant(cnt, 2));
            chk(int'(free_code) == quant(EXP_DEPTH - cnt, 2), "R9 free_code",
                int'(free_code), quant(EXP_DEPTH - cnt, 2));
            chk(fill_b == 1'b0, "R11 removed fill code", int'(fill_b), 0);
            chk(int'(free_b) == quant(EXP_DEPTH - cnt, 1), "R9 free_code 1-bit",
                int'(free_b), quant(EXP_DEPTH - cnt, 1));
            if (cnt > 0) begin
                chk(dout == q[0], "R5 head word order", int'(dout), int'(q[0]));
                chk(dout_b == q[0], "R5 head word second instance", int'(dout_b), int'(q[0]));
            end
            pa = put && (cnt < EXP_DEPTH);
            ga = got && (cnt > 0);
            if (ga) void'(q.pop_front());
            cnt = cnt + int'(pa) - int'(ga);
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state while reset is held
        chk(!valid && !full, "R1 flags in reset", int'({valid, full}), 0);
        chk(fill_code == 2'd0, "R1 fill_code in reset", int'(fill_code), 0);
        chk(free_code == 2'd3, "R1 free_code in reset", int'(free_code), 3);
        @(posedge clk); #1; rst = 1'b0;

        // R7: got on empty is ignored, put in the same cycle is stored
        step(1, 1);
        step(0, 0);
        @(negedge clk);
        chk(valid == 1'b1, "R7 valid after put with got on empty", int'(valid), 1);

        // R6: balanced put and got with one word stored
        for (int i = 0; i < 5; i++) step(1, 1);

        // R2/R3/R10: fill past capacity, keep pushing while full
        for (int i = 0; i < 22; i++) step(1, 0);
        step(0, 0);
        @(negedge clk);
        chk(full == 1'b1, "R10 full after 16 words", int'(full), 1);
        chk(fill_code == 2'd3 && free_code == 2'd0, "R8/R9 codes at full",
            int'({fill_code, free_code}), 12);

        // R6: balanced traffic from full-1
        step(0, 1);
        for (int i = 0; i < 4; i++) step(1, 1);

        // R3/R5: drain everything; refused words must never appear
        for (int i = 0; i < 20; i++) step(0, 1);
        step(0, 0);
        @(negedge clk);
        chk(valid == 1'b0, "R4 empty after drain", int'(valid), 0);

        // Mixed traffic, write-biased then read-biased
        for (int i = 0; i < 300; i++) step($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0);
        for (int i = 0; i < 300; i++) step($urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0);

        // R1: reset in the middle of operation
        for (int i = 0; i < 6; i++) step(1, 0);
        @(posedge clk); #1; put = 0; got = 0; rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        chk(!valid && !full, "R1 flags after mid-run reset", int'({valid, full}), 0);
        chk(free_code == 2'd3, "R1 free_code after mid-run reset", int'(free_code), 3);
        step(0, 0);
        step(0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule